// File: doc/BRIEF.md
# Critical-Word-First Line Fill Unit

This block handles one cache read miss at a time. It takes the missed byte address and fetches all four words of the block that holds it from the next memory level. It hands the missed word to the processor as soon as that word comes back, without waiting for the whole block. Each returned word goes into a line buffer. When the last word has arrived, the block is written into the data array in a single write, together with its tag, and the line is marked valid.

A parameter sets the order in which the words are requested. In wrap mode the first request is for the missed word, and the following requests step upward through the block, wrapping modulo the block size. In linear mode the words are always requested from offset 0 upward, and the processor is released when the missed word arrives.

The address is split into an 18-bit tag in bits 31:14, a 10-bit index in bits 13:4, a 2-bit word select in bits 3:2 and a 2-bit byte-in-word field in bits 1:0. The memory side sends requests with a ready handshake. It returns exactly one data word for each accepted request, in request order.

Top module: `cwf_line_fill`

## Requirements
- R1: A miss is accepted in a cycle where `miss_valid` is high and `busy` is low. `busy` is high from the next cycle and goes low in the cycle where `fill_we` is high.
- R2: Each accepted miss produces exactly four memory requests. Each request address is the block address with the word select in bits 3:2 and zeros in bits 1:0. No request is issued while `busy` is low.
- R3: In wrap mode the word selects of the four requests are c, c+1, c+2 and c+3, all modulo 4, where c is `miss_addr[3:2]`.
- R4: In linear mode the word selects of the four requests are 0, 1, 2 and 3, in that order.
- R5: `cpu_rsp_valid` is high for exactly one cycle per miss. That cycle is the one after the memory returns the word at the missed word select. `cpu_rsp_data` then equals that word.
- R6: Word w of the block appears on `fill_line[32w+31:32w]`. `fill_index` equals `miss_addr[13:4]` and `fill_tag` equals `miss_addr[31:14]`.
- R7: `fill_we` is high for exactly one cycle per miss. That cycle is the one after the fourth returned word, and never earlier.
- R8: `miss_valid` is ignored while `busy` is high. No extra requests, data returns or fills result.
- R9: During reset `busy`, `mem_req_valid`, `cpu_rsp_valid` and `fill_we` are all low.
- R10: While `mem_req_valid` is high and `mem_req_ready` is low, the request is held: in the next cycle `mem_req_valid` stays high and `mem_req_addr` is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| miss_valid | input | 1 | A read miss is presented |
| miss_addr | input | 32 | Byte address of the missed word |
| busy | output | 1 | A fill is in progress; new misses are not taken |
| mem_req_valid | output | 1 | A word request is offered to memory |
| mem_req_ready | input | 1 | Memory takes the offered request |
| mem_req_addr | output | 32 | Byte address of the requested word |
| mem_rsp_valid | input | 1 | A returned word is present |
| mem_rsp_data | input | 32 | Returned word, in request order |
| cpu_rsp_valid | output | 1 | One-cycle pulse carrying the missed word |
| cpu_rsp_data | output | 32 | The missed word |
| fill_we | output | 1 | Write the whole line, its tag and its valid bit |
| fill_index | output | 10 | Line index to write |
| fill_tag | output | 18 | Tag to store with the line |
| fill_line | output | 128 | All four words of the block, word w at bits 32w+31:32w |

## Verification
The hardest case to reach is in linear mode with the missed word at select 3. There the processor pulse, the line write and the acceptance of the next miss all fall in one cycle. The same case has to be reached while requests are stalled and returns have gaps. The bench drives two instances, one per ordering mode, with the same misses. It cycles the missed word select through every value, and it offers each next miss in the very cycle `busy` falls. A pseudo-random pattern withholds `mem_req_ready` and delays returns. A separate run injects a foreign miss in the middle of a fill.

// File: rtl/cwf_pkg.sv
package cwf_pkg;
  // Order in which the words of a block are requested from memory.
  typedef enum logic {
    ORDER_WRAP   = 1'b0,  // missed word first, then wrap upward
    ORDER_LINEAR = 1'b1   // ascending from word 0
  } fill_order_e;
endpackage

// File: rtl/cwf_order_gen.sv
// Maps a beat number (0..WORDS-1) to the word select it carries.
module cwf_order_gen #(
  parameter int unsigned          WSEL_W     = 2,
  parameter cwf_pkg::fill_order_e FILL_ORDER = cwf_pkg::ORDER_WRAP
) (
  input  logic [WSEL_W-1:0] crit_sel,
  input  logic [WSEL_W-1:0] beat,
  output logic [WSEL_W-1:0] word_sel
);
  generate
    if (FILL_ORDER == cwf_pkg::ORDER_WRAP) begin : g_wrap
      // power-of-two block: the adder wraps modulo the block size
      assign word_sel = crit_sel + beat;
    end else begin : g_linear
      wire unused_crit = ^crit_sel;
      assign word_sel = beat;
    end
  endgenerate
endmodule

// File: rtl/cwf_req_issuer.sv
// Issues WORDS consecutive request beats after each start pulse.
module cwf_req_issuer #(
  parameter int unsigned WORDS = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     start,
  input  logic                     ready,
  output logic                     req_valid,
  output logic [$clog2(WORDS)-1:0] beat
);
  localparam int unsigned WSEL_W = $clog2(WORDS);
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  logic              run_q;
  logic [WSEL_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (start) begin
      run_q <= 1'b1;
      cnt_q <= '0;
    end else if (run_q && ready) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q == LAST_BEAT) run_q <= 1'b0;
    end
  end

  assign req_valid = run_q;
  assign beat      = cnt_q;
endmodule

// File: rtl/cwf_line_buffer.sv
// Collects the returned words of one block; all words readable at once.
module cwf_line_buffer #(
  parameter int unsigned WORDS  = 4,
  parameter int unsigned DATA_W = 32
) (
  input  logic                     clk,
  input  logic                     we,
  input  logic [$clog2(WORDS)-1:0] wsel,
  input  logic [DATA_W-1:0]        wdata,
  output logic [WORDS*DATA_W-1:0]  line
);
  logic [DATA_W-1:0] word_q [WORDS];

  always_ff @(posedge clk) begin
    if (we) word_q[wsel] <= wdata;
  end

  generate
    for (genvar w = 0; w < WORDS; w++) begin : g_pack
      assign line[w*DATA_W +: DATA_W] = word_q[w];
    end
  endgenerate
endmodule

// File: rtl/cwf_line_fill.sv
module cwf_line_fill #(
  parameter int unsigned          ADDR_W     = 32,
  parameter int unsigned          DATA_W     = 32,
  parameter int unsigned          WORDS      = 4,
  parameter int unsigned          IDX_W      = 10,
  parameter cwf_pkg::fill_order_e FILL_ORDER = cwf_pkg::ORDER_WRAP,
  localparam int unsigned WSEL_W = $clog2(WORDS),
  localparam int unsigned BIW_W  = $clog2(DATA_W / 8),
  localparam int unsigned BOFF_W = WSEL_W + BIW_W,
  localparam int unsigned TAG_W  = ADDR_W - IDX_W - BOFF_W
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    miss_valid,
  input  logic [ADDR_W-1:0]       miss_addr,
  output logic                    busy,
  output logic                    mem_req_valid,
  input  logic                    mem_req_ready,
  output logic [ADDR_W-1:0]       mem_req_addr,
  input  logic                    mem_rsp_valid,
  input  logic [DATA_W-1:0]       mem_rsp_data,
  output logic                    cpu_rsp_valid,
  output logic [DATA_W-1:0]       cpu_rsp_data,
  output logic                    fill_we,
  output logic [IDX_W-1:0]        fill_index,
  output logic [TAG_W-1:0]        fill_tag,
  output logic [WORDS*DATA_W-1:0] fill_line
);
  localparam int unsigned BLK_W = ADDR_W - BOFF_W;
  localparam logic [WSEL_W-1:0] LAST_BEAT = WSEL_W'(WORDS - 1);

  logic              active_q;
  logic [BLK_W-1:0]  blk_q;
  logic [WSEL_W-1:0] crit_q;
  logic [WSEL_W-1:0] rbeat_q;
  logic              cpu_v_q;
  logic [DATA_W-1:0] cpu_d_q;
  logic              fill_we_q;

  logic              accept;
  logic              take;
  logic              take_last;
  logic              take_crit;
  logic [WSEL_W-1:0] req_beat;
  logic [WSEL_W-1:0] req_sel;
  logic [WSEL_W-1:0] rsp_sel;

  wire unused_byte_bits = ^miss_addr[BIW_W-1:0];

  assign accept    = miss_valid && !active_q;
  assign take      = active_q && mem_rsp_valid;
  assign take_last = take && (rbeat_q == LAST_BEAT);
  assign take_crit = take && (rsp_sel == crit_q);

  // request side
  cwf_req_issuer #(.WORDS(WORDS)) u_issuer (
    .clk       (clk),
    .rst       (rst),
    .start     (accept),
    .ready     (mem_req_ready),
    .req_valid (mem_req_valid),
    .beat      (req_beat)
  );

  cwf_order_gen #(.WSEL_W(WSEL_W), .FILL_ORDER(FILL_ORDER)) u_req_order (
    .crit_sel (crit_q),
    .beat     (req_beat),
    .word_sel (req_sel)
  );

  assign mem_req_addr = {blk_q, req_sel, {BIW_W{1'b0}}};

  // return side: same ordering rule tells which word each beat carries
  cwf_order_gen #(.WSEL_W(WSEL_W), .FILL_ORDER(FILL_ORDER)) u_rsp_order (
    .crit_sel (crit_q),
    .beat     (rbeat_q),
    .word_sel (rsp_sel)
  );

  cwf_line_buffer #(.WORDS(WORDS), .DATA_W(DATA_W)) u_linebuf (
    .clk   (clk),
    .we    (take),
    .wsel  (rsp_sel),
    .wdata (mem_rsp_data),
    .line  (fill_line)
  );

  // control state
  always_ff @(posedge clk) begin
    if (rst) begin
      active_q  <= 1'b0;
      rbeat_q   <= '0;
      cpu_v_q   <= 1'b0;
      fill_we_q <= 1'b0;
    end else begin
      cpu_v_q   <= take_crit;
      fill_we_q <= take_last;
      if (accept) begin
        active_q <= 1'b1;
        rbeat_q  <= '0;
      end else if (take) begin
        rbeat_q <= rbeat_q + 1'b1;
        if (take_last) active_q <= 1'b0;
      end
    end
  end

  // datapath registers, no reset needed
  always_ff @(posedge clk) begin
    if (accept) begin
      blk_q  <= miss_addr[ADDR_W-1:BOFF_W];
      crit_q <= miss_addr[BOFF_W-1:BIW_W];
    end
    if (take_crit) cpu_d_q <= mem_rsp_data;
  end

  assign busy          = active_q;
  assign cpu_rsp_valid = cpu_v_q;
  assign cpu_rsp_data  = cpu_d_q;
  assign fill_we       = fill_we_q;
  assign fill_index    = blk_q[IDX_W-1:0];
  assign fill_tag      = blk_q[BLK_W-1:IDX_W];
endmodule

// File: rtl/cwf_line_fill_chk.sv
module cwf_line_fill_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              miss_valid,
  input logic              busy,
  input logic              mem_req_valid,
  input logic              mem_req_ready,
  input logic [ADDR_W-1:0] mem_req_addr,
  input logic              cpu_rsp_valid,
  input logic              fill_we
);
  AST_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (rst)
    (!busy && miss_valid) |=> busy); // R1

  AST_FILL_ENDS_BUSY: assert property (@(posedge clk) disable iff (rst)
    fill_we |-> !busy); // R1

  AST_NO_REQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !mem_req_valid); // R2

  AST_CPU_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |=> !cpu_rsp_valid); // R5

  AST_CPU_IN_FILL: assert property (@(posedge clk) disable iff (rst)
    cpu_rsp_valid |-> $past(busy)); // R5

  AST_FILL_SINGLE: assert property (@(posedge clk) disable iff (rst)
    fill_we |=> !fill_we); // R7

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10
endmodule

bind cwf_line_fill cwf_line_fill_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/cwf_line_fill_tb.sv
// Memory model: answers accepted requests in order, one word per cycle
// unless hold is high.
module cwf_mem_model (
  input  logic        clk,
  input  logic        rst,
  input  logic        req_valid,
  input  logic        req_ready,
  input  logic [31:0] req_addr,
  input  logic        hold,
  output logic        rsp_valid,
  output logic [31:0] rsp_data
);
  logic [31:0] pend[$];

  function automatic logic [31:0] word_at(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] ^ 16'h1E0F};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      pend.delete();
      rsp_valid <= 1'b0;
      rsp_data  <= '0;
    end else begin
      if (req_valid && req_ready) pend.push_back(req_addr);
      if (!hold && pend.size() > 0) begin
        rsp_valid <= 1'b1;
        rsp_data  <= word_at(pend.pop_front());
      end else begin
        rsp_valid <= 1'b0;
      end
    end
  end
endmodule

module cwf_line_fill_tb;
  typedef struct {
    logic [9:0]   idx;
    logic [17:0]  tag;
    logic [127:0] line;
  } fill_t;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst;
  logic        miss_valid;
  logic [31:0] miss_addr;
  logic        mem_req_ready;
  logic        hold;
  logic        stall_en;
  logic [7:0]  lf;

  logic         busy      [2];
  logic         req_v     [2];
  logic [31:0]  req_a     [2];
  logic         rsp_v     [2];
  logic [31:0]  rsp_d     [2];
  logic         cpu_v     [2];
  logic [31:0]  cpu_d     [2];
  logic         fwe       [2];
  logic [9:0]   fidx      [2];
  logic [17:0]  ftag      [2];
  logic [127:0] fline     [2];

  int n_checks = 0;
  int n_fail   = 0;
  bit timed_out = 0;

  logic [31:0] q_req[$];   // interleaved: wrap instance, then linear instance
  fill_t       q_fill[$];  // interleaved the same way
  logic [31:0] q_cpu0[$];
  logic [31:0] q_cpu1[$];

  int          rcnt       [2];
  logic        prev_rsp_v [2];
  logic [31:0] prev_rsp_d [2];
  logic        prev_stall [2];
  logic [31:0] prev_addr  [2];

  cwf_line_fill #(.FILL_ORDER(cwf_pkg::ORDER_WRAP)) u_dut (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .busy(busy[0]), .mem_req_valid(req_v[0]), .mem_req_ready(mem_req_ready),
    .mem_req_addr(req_a[0]), .mem_rsp_valid(rsp_v[0]), .mem_rsp_data(rsp_d[0]),
    .cpu_rsp_valid(cpu_v[0]), .cpu_rsp_data(cpu_d[0]), .fill_we(fwe[0]),
    .fill_index(fidx[0]), .fill_tag(ftag[0]), .fill_line(fline[0]));

  cwf_line_fill #(.FILL_ORDER(cwf_pkg::ORDER_LINEAR)) u_dut_lin (
    .clk(clk), .rst(rst), .miss_valid(miss_valid), .miss_addr(miss_addr),
    .busy(busy[1]), .mem_req_valid(req_v[1]), .mem_req_ready(mem_req_ready),
    .mem_req_addr(req_a[1]), .mem_rsp_valid(rsp_v[1]), .mem_rsp_data(rsp_d[1]),
    .cpu_rsp_valid(cpu_v[1]), .cpu_rsp_data(cpu_d[1]), .fill_we(fwe[1]),
    .fill_index(fidx[1]), .fill_tag(ftag[1]), .fill_line(fline[1]));

  cwf_mem_model u_mem0 (.clk(clk), .rst(rst), .req_valid(req_v[0]), .req_ready(mem_req_ready),
    .req_addr(req_a[0]), .hold(hold), .rsp_valid(rsp_v[0]), .rsp_data(rsp_d[0]));
  cwf_mem_model u_mem1 (.clk(clk), .rst(rst), .req_valid(req_v[1]), .req_ready(mem_req_ready),
    .req_addr(req_a[1]), .hold(hold), .rsp_valid(rsp_v[1]), .rsp_data(rsp_d[1]));

  // expected memory contents, written from the bench's own rule
  function automatic logic [31:0] exp_word(input logic [31:0] a);
    return {a[15:0] ^ 16'hC3A5, a[31:16] ^ 16'h1E0F};
  endfunction

  task automatic chk(input bit ok, input string rq, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", rq, act, exp);
    end
  endtask

  // stall pattern for ready and return gaps
  initial lf = 8'h5B;
  always @(negedge clk) begin
    if (stall_en) begin
      lf = {lf[6:0], lf[7] ^ lf[5] ^ lf[4] ^ lf[3]};
      mem_req_ready = lf[0] | lf[2];
      hold          = lf[1] & lf[6];
    end else begin
      mem_req_ready = 1'b1;
      hold          = 1'b0;
    end
  end

  // monitor: compares every observed event with the scoreboard
  always @(negedge clk) begin
    if (!rst) begin
      for (int m = 0; m < 2; m++) begin
        if (prev_stall[m])
          chk(req_v[m] && req_a[m] == prev_addr[m], "R10 request held", {req_v[m], req_a[m]}, {1'b1, prev_addr[m]});
        prev_stall[m] = req_v[m] && !mem_req_ready;
        prev_addr[m]  = req_a[m];

        if (req_v[m] && mem_req_ready) begin
          if (q_req.size() == 0) chk(1'b0, "R2 unexpected request", req_a[m], 0);
          else begin
            logic [31:0] e;
            e = q_req.pop_front();
            chk(req_a[m] == e, m == 0 ? "R2 R3 wrap order" : "R2 R4 linear order", req_a[m], e);
          end
        end

        if (cpu_v[m]) begin
          logic [31:0] e;
          bit          have;
          have = (m == 0) ? (q_cpu0.size() > 0) : (q_cpu1.size() > 0);
          if (!have) chk(1'b0, "R5 unexpected cpu pulse", cpu_d[m], 0);
          else begin
            e = (m == 0) ? q_cpu0.pop_front() : q_cpu1.pop_front();
            chk(cpu_d[m] == e, "R5 missed word data", cpu_d[m], e);
            chk(prev_rsp_v[m] && prev_rsp_d[m] == e, "R5 forwarded in cycle after arrival",
                {prev_rsp_v[m], prev_rsp_d[m]}, {1'b1, e});
          end
        end

        if (fwe[m]) begin
          chk(rcnt[m] == 4, "R7 fill only after four words", rcnt[m], 4);
          rcnt[m] = 0;
          chk(!busy[m], "R1 busy low with fill", busy[m], 0);
          if (q_fill.size() == 0) chk(1'b0, "R7 unexpected fill", fidx[m], 0);
          else begin
            fill_t f;
            f = q_fill.pop_front();
            chk(fidx[m] == f.idx, "R6 fill index", fidx[m], f.idx);
            chk(ftag[m] == f.tag, "R6 fill tag", ftag[m], f.tag);
            chk(fline[m] == f.line, "R6 fill line", fline[m], f.line);
          end
        end

        if (rsp_v[m]) rcnt[m]++;
        prev_rsp_v[m] = rsp_v[m];
        prev_rsp_d[m] = rsp_d[m];
      end
    end
  end

  // driver: offers a miss when both instances are idle and records what must follow
  task automatic issue_miss(input logic [31:0] a, input bit intrude);
    logic [1:0] c;
    fill_t      f;
    while (busy[0] || busy[1]) @(negedge clk);
    c = a[3:2];
    for (int k = 0; k < 4; k++) begin
      q_req.push_back({a[31:4], 2'(c + k), 2'b00});
      q_req.push_back({a[31:4], 2'(k), 2'b00});
    end
    q_cpu0.push_back(exp_word({a[31:4], c, 2'b00}));
    q_cpu1.push_back(exp_word({a[31:4], c, 2'b00}));
    f.idx = a[13:4];
    f.tag = a[31:14];
    for (int w = 0; w < 4; w++) f.line[w*32 +: 32] = exp_word({a[31:4], 2'(w), 2'b00});
    q_fill.push_back(f);
    q_fill.push_back(f);
    miss_valid = 1'b1;
    miss_addr  = a;
    @(negedge clk);
    miss_valid = 1'b0;
    chk(busy[0] && busy[1], "R1 busy after accept", {busy[0], busy[1]}, 2'b11);
    if (intrude) begin
      @(negedge clk);
      miss_valid = 1'b1;
      miss_addr  = 32'hDEAD_BEE4;
      @(negedge clk);
      miss_valid = 1'b0;
      chk(busy[0] && busy[1], "R8 busy kept through foreign miss", {busy[0], busy[1]}, 2'b11);
    end
  endtask

  task automatic run_test();
    issue_miss(32'h0000_0014, 0);
    issue_miss(32'h0000_001C, 0);
    issue_miss(32'h0000_0034, 0);
    issue_miss(32'h0000_8014, 0);
    issue_miss(32'hFFFF_FFF8, 0);
    issue_miss(32'h1234_5670, 0);
    issue_miss(32'h0000_1238, 1);
    stall_en = 1'b1;
    for (int i = 0; i < 12; i++)
      issue_miss(32'h4000_0000 + i * 32'h0002_0410 + (i % 4) * 4, 0);
    issue_miss(32'h0BAD_F00C, 1);
    stall_en = 1'b0;
    while (busy[0] || busy[1]) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst = 1'b1;
    miss_valid = 1'b0;
    miss_addr = '0;
    stall_en = 1'b0;
    mem_req_ready = 1'b1;
    hold = 1'b0;
    for (int m = 0; m < 2; m++) begin
      rcnt[m] = 0;
      prev_rsp_v[m] = 1'b0;
      prev_rsp_d[m] = '0;
      prev_stall[m] = 1'b0;
      prev_addr[m] = '0;
    end
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      chk(!busy[m] && !req_v[m] && !cpu_v[m] && !fwe[m], "R9 reset outputs",
          {busy[m], req_v[m], cpu_v[m], fwe[m]}, 4'b0000);
    end
    rst = 1'b0;
    fork
      run_test();
      begin
        repeat (20000) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    chk(q_req.size() == 0, "R2 all requests seen", q_req.size(), 0);
    chk(q_cpu0.size() == 0 && q_cpu1.size() == 0, "R5 one pulse per miss",
        q_cpu0.size() + q_cpu1.size(), 0);
    chk(q_fill.size() == 0, "R7 one fill per miss", q_fill.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule